// File: doc/BRIEF.md
# 8-bit arithmetic flag generator

This block computes the 8-bit result and the full flag byte of an 8-bit CPU's add, subtract and negate operations. The flag byte is exact to the bit. That includes the two undocumented bits that copy result bits 3 and 5, and the special carry and overflow rules that negate follows. The arithmetic and flag logic is purely combinational. A thin registered wrapper captures the outputs whenever the caller raises a one-cycle valid strobe, so the block can sit behind an execution stage that issues at most one operation per clock.

The wrapper is a two-state machine. After reset it sits in `ST_IDLE`. The transition CAPTURE (strobe high) moves it to `ST_SHOW`, and the result and flag registers load in that same edge. From `ST_SHOW`, RECAPTURE (strobe high again) stays in `ST_SHOW` with fresh data, and EXPIRE (strobe low) returns it to `ST_IDLE`. In `ST_IDLE` the result and flag registers keep their last values. `out_valid` is high exactly while the machine is in `ST_SHOW`.

Top module: `afg_top`

## Requirements
- R1: The result is acc+opnd mod 256 for op code 0 (add), acc-opnd mod 256 for code 1 (subtract) and 0-opnd mod 256 for code 2 (negate). Code 3 behaves as add.
- R2: The flag byte has carry in bit 0, subtract in bit 1, parity/overflow in bit 2, X in bit 3, half carry in bit 4, Y in bit 5, zero in bit 6 and sign in bit 7. For example, 0x7F+0x01 yields 0x94, negate of 0x80 yields 0x87, negate of 0x00 yields 0x42 and 0x00-0x01 yields 0xBB.
- R3: Carry is the unsigned carry out for add and the unsigned borrow (acc < opnd) for subtract. For negate, carry is set exactly when opnd is nonzero.
- R4: The subtract flag (bit 1) is 0 for add and 1 for subtract and negate.
- R5: For add and subtract, bit 2 is set exactly when the true signed result lies outside -128..127.
- R6: For negate, bit 2 is set only when opnd is 0x80, and the acc input has no effect on the result or on any flag.
- R7: Half carry (bit 4) is set when the low nibble produces a carry (add) or a borrow (subtract, and negate taken as 0 minus opnd).
- R8: Sign copies result bit 7. Zero is set when the result is 0x00. Y and X copy result bits 5 and 3.
- R9: An operation presented with `in_valid` high appears on `result`/`flags` after the next rising edge, with `out_valid` high for exactly that cycle per strobe.
- R10: While `in_valid` is low, `result` and `flags` hold their values and `op`, `acc` and `opnd` have no effect.
- R11: During reset, `out_valid`, `result` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: capture the current operation |
| op | input | 2 | Operation code: 0 add, 1 subtract, 2 negate, 3 add |
| acc | input | 8 | Accumulator operand (ignored by negate) |
| opnd | input | 8 | Second operand |
| out_valid | output | 1 | High for the cycle after each strobe |
| result | output | 8 | Registered 8-bit result |
| flags | output | 8 | Registered flag byte |

## Verification
The bench builds the block with its default 8-bit data width. At that width every acc/opnd pair is reachable, so add and subtract are driven exhaustively over all 65,536 pairs each, back to back with the strobe held high. Negate is swept over all 256 operands under several accumulator values, which exposes any leak of acc into its flags. Directed vectors separated by idle gaps cover the full flag byte values, the hold behaviour with changing inputs, and the 0x80 and 0x00 negate corners.

// File: rtl/afg_pkg.sv
package afg_pkg;

    // Flag byte geometry: positions are fixed by what downstream logic decodes
    localparam int FLAG_W  = 8;
    localparam int FB_C    = 0;
    localparam int FB_N    = 1;
    localparam int FB_PV   = 2;
    localparam int FB_X    = 3;
    localparam int FB_H    = 4;
    localparam int FB_Y    = 5;
    localparam int FB_Z    = 6;
    localparam int FB_S    = 7;

    typedef enum logic [1:0] {
        OP_ADD     = 2'd0,
        OP_SUB     = 2'd1,
        OP_NEG     = 2'd2,
        OP_ADD_ALT = 2'd3
    } afg_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } afg_state_e;

    // Packed MSB first, so the field order equals the bit layout above
    typedef struct packed {
        logic sign;
        logic zero;
        logic ybit;
        logic half;
        logic xbit;
        logic pv;
        logic subtract;
        logic carry;
    } afg_flags_t;

endpackage

// File: rtl/afg_arith.sv
module afg_arith
    import afg_pkg::*;
#(
    parameter int DW = 8
) (
    input  afg_op_e         op,
    input  logic [DW-1:0]   acc,
    input  logic [DW-1:0]   opnd,
    output logic [DW-1:0]   res,
    output logic            carry,
    output logic            half,
    output logic            ovf,
    output logic            subtract
);

    localparam int MSB = DW - 1;
    localparam int HB  = DW / 2;
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] lhs;
    logic          is_sub;
    logic [DW:0]   raw;
    logic [DW-1:0] low;
    logic [DW-1:0] nib_vec;

    // Operand steering: negate is a subtract from zero
    always_comb begin
        lhs    = acc;
        is_sub = 1'b0;
        unique case (op)
            OP_ADD, OP_ADD_ALT: begin
                lhs    = acc;
                is_sub = 1'b0;
            end
            OP_SUB: begin
                lhs    = acc;
                is_sub = 1'b1;
            end
            OP_NEG: begin
                lhs    = '0;
                is_sub = 1'b1;
            end
        endcase
    end

    always_comb begin
        if (is_sub) begin
            raw = {1'b0, lhs} - {1'b0, opnd};
        end else begin
            raw = {1'b0, lhs} + {1'b0, opnd};
        end
        low     = raw[MSB:0];
        nib_vec = lhs ^ opnd ^ low;
    end

    assign res      = low;
    assign half     = nib_vec[HB];
    assign subtract = is_sub;

    // Carry and overflow rules differ per operation
    always_comb begin
        carry = raw[DW];
        ovf   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADD_ALT: begin
                carry = raw[DW];
                ovf   = ~(lhs[MSB] ^ opnd[MSB]) & (opnd[MSB] ^ low[MSB]);
            end
            OP_SUB: begin
                carry = raw[DW];
                ovf   = (lhs[MSB] ^ opnd[MSB]) & (lhs[MSB] ^ low[MSB]);
            end
            OP_NEG: begin
                carry = |opnd;
                ovf   = (opnd == MOST_NEG);
            end
        endcase
    end

endmodule

// File: rtl/afg_szxy.sv
module afg_szxy #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] res,
    output logic          sign,
    output logic          zero,
    output logic          ybit,
    output logic          xbit
);

    localparam int MSB = DW - 1;
    localparam int XB  = DW / 2 - 1;
    localparam int YB  = DW / 2 + 1;

    // Purely a function of the result byte
    always_comb begin
        sign = res[MSB];
        zero = ~|res;
        ybit = res[YB];
        xbit = res[XB];
    end

endmodule

// File: rtl/afg_core.sv
module afg_core
    import afg_pkg::*;
#(
    parameter int DW = 8
) (
    input  afg_op_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] res,
    output afg_flags_t    flg
);

    logic c_w, h_w, v_w, n_w;
    logic s_w, z_w, y_w, x_w;

    afg_arith #(.DW(DW)) u_arith (
        .op       (op),
        .acc      (acc),
        .opnd     (opnd),
        .res      (res),
        .carry    (c_w),
        .half     (h_w),
        .ovf      (v_w),
        .subtract (n_w)
    );

    afg_szxy #(.DW(DW)) u_szxy (
        .res  (res),
        .sign (s_w),
        .zero (z_w),
        .ybit (y_w),
        .xbit (x_w)
    );

    always_comb begin
        flg.sign     = s_w;
        flg.zero     = z_w;
        flg.ybit     = y_w;
        flg.half     = h_w;
        flg.xbit     = x_w;
        flg.pv       = v_w;
        flg.subtract = n_w;
        flg.carry    = c_w;
    end

endmodule

// File: rtl/afg_top.sv
module afg_top
    import afg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op,
    input  logic [DW-1:0]     acc,
    input  logic [DW-1:0]     opnd,
    output logic              out_valid,
    output logic [DW-1:0]     result,
    output logic [FLAG_W-1:0] flags
);

    afg_state_e    state_q, state_d;
    logic [DW-1:0] res_c;
    afg_flags_t    flg_c;

    afg_core #(.DW(DW)) u_core (
        .op   (afg_op_e'(op)),
        .acc  (acc),
        .opnd (opnd),
        .res  (res_c),
        .flg  (flg_c)
    );

    // Transitions: CAPTURE, RECAPTURE, EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            flags  <= '0;
        end else if (in_valid) begin
            result <= res_c;
            flags  <= flg_c;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

endmodule

// File: rtl/afg_top_chk.sv
module afg_top_chk
    import afg_pkg::*;
#(
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op,
    input logic [DW-1:0]     opnd,
    input logic              out_valid,
    input logic [DW-1:0]     result,
    input logic [FLAG_W-1:0] flags
);

    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    p_valid_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags)));

    p_sub_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 2'd1 || op == 2'd2)) |=> flags[FB_N]);

    p_neg_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd2) |=> (flags[FB_C] == ($past(opnd) != '0)));

    p_neg_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'd2) |=> (flags[FB_PV] == ($past(opnd) == MOST_NEG)));

    p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags[FB_Z] == (result == '0)));

    p_sign_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flags[FB_S] == result[DW-1]));

endmodule

bind afg_top afg_top_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opnd      (opnd),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags)
);

// File: tb/afg_top_test.sv
module afg_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] res;
        logic [7:0] flg;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] acc = 8'd0;
    logic [7:0] opnd = 8'd0;
    logic       out_valid;
    logic [7:0] result;
    logic [7:0] flags;

    exp_t sb_q[$];
    exp_t last_exp;
    int   checks = 0;
    int   errors = 0;
    int   strobes = 0;
    int   seen = 0;
    bit   done = 1'b0;

    afg_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .acc       (acc),
        .opnd      (opnd),
        .out_valid (out_valid),
        .result    (result),
        .flags     (flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model from the requirements, using integer arithmetic
    function automatic exp_t model(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b);
        exp_t e;
        int ia, ib, sa, sb, r, sr;
        bit c, h, v, n;
        logic [7:0] rb;
        ia = a; ib = b;
        sa = a[7] ? ia - 256 : ia;
        sb = b[7] ? ib - 256 : ib;
        case (o)
            2'd1: begin
                r = ia - ib; c = (ia < ib); h = ((ia % 16) < (ib % 16));
                sr = sa - sb; v = (sr > 127) || (sr < -128); n = 1'b1;
            end
            2'd2: begin
                r = -ib; c = (ib != 0); h = ((ib % 16) != 0);
                v = (ib == 128); n = 1'b1;
            end
            default: begin
                r = ia + ib; c = (r > 255); h = (((ia % 16) + (ib % 16)) > 15);
                sr = sa + sb; v = (sr > 127) || (sr < -128); n = 1'b0;
            end
        endcase
        rb = r[7:0];
        e.op  = o;
        e.res = rb;
        e.flg = {rb[7], (rb == 8'd0), rb[5], h, rb[3], v, n, c};
        return e;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b);
        exp_t e;
        @(negedge clk);
        op = o; acc = a; opnd = b; in_valid = 1'b1;
        e = model(o, a, b);
        sb_q.push_back(e);
        last_exp = e;
        strobes++;
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pop expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                chk("R9 out_valid without pending strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                seen++;
                chk("R1 result", result, e.res);
                chk("R3 carry", flags[0], e.flg[0]);
                chk("R4 subtract flag", flags[1], e.flg[1]);
                if (e.op == 2'd2) chk("R6 negate overflow", flags[2], e.flg[2]);
                else              chk("R5 overflow", flags[2], e.flg[2]);
                chk("R7 half carry", flags[4], e.flg[4]);
                chk("R8 sign/zero/Y/X", {flags[7:5], flags[3]}, {e.flg[7:5], e.flg[3]});
            end
        end
    end

    // Directed vector with full-byte expectation (R2), checked while idle
    task automatic directed(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] xres, input logic [7:0] xflg);
        drive(o, a, b);
        go_idle();
        @(negedge clk);
        chk("R2 flag byte layout", flags, xflg);
        chk("R1 directed result", result, xres);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset values
        repeat (3) @(negedge clk);
        chk("R11 reset out_valid", out_valid, 0);
        chk("R11 reset result", result, 0);
        chk("R11 reset flags", flags, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 no valid before strobe", out_valid, 0);

        // R2 directed corners
        directed(2'd0, 8'h7F, 8'h01, 8'h80, 8'h94);
        directed(2'd2, 8'h33, 8'h80, 8'h80, 8'h87);
        directed(2'd2, 8'hC4, 8'h00, 8'h00, 8'h42);
        directed(2'd1, 8'h00, 8'h01, 8'hFF, 8'hBB);

        // R10: inputs change while in_valid is low; outputs hold
        drive(2'd0, 8'h12, 8'h34);
        go_idle();
        for (int k = 0; k < 3; k++) begin
            op = 2'(k); acc = 8'(8'hA5 + k); opnd = 8'(8'h5A - k);
            @(negedge clk);
            chk("R10 out_valid low while idle", out_valid, 0);
            chk("R10 result held", result, last_exp.res);
            chk("R10 flags held", flags, last_exp.flg);
        end

        // R1/R3/R5/R7/R8: exhaustive add and subtract, back to back (R9)
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                drive(2'd0, 8'(a), 8'(b));
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                drive(2'd1, 8'(b), 8'(a));

        // R1: code 3 aliases add
        for (int b = 0; b < 256; b++)
            drive(2'd3, 8'(b * 7), 8'(b));

        // R6: negate sweep under several accumulator values
        for (int q = 0; q < 4; q++)
            for (int b = 0; b < 256; b++)
                drive(2'd2, (q == 0) ? 8'h00 : (q == 1) ? 8'hFF : (q == 2) ? 8'h5A : 8'h80, 8'(b));

        go_idle();
        repeat (3) @(negedge clk);
        chk("R9 one output per strobe", seen, strobes);
        chk("R9 scoreboard drained", sb_q.size(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule